// File: doc/BRIEF.md
# Isochronous IN Ping-Pong Endpoint Buffer

This block is the transmit buffer of an isochronous IN endpoint. It holds two byte banks. At any moment one bank belongs to the CPU side and the other to the serial-engine side. The CPU pushes the bytes of one packet through a single write port and never selects a bank. The serial engine asks for a packet with an IN-token strobe. It then pulls bytes over a valid/ready stream and receives a one-cycle transfer-done pulse. Each start-of-frame (SOF) pulse swaps the two banks. A packet written during frame N is therefore sent during frame N+1, and the CPU and the engine never touch the same bank.

A frame timer reloads from a programmable value on each SOF. If the next SOF does not arrive before the timer runs out, the timer raises a one-cycle interrupt and no swap takes place. The stale packet on the transmit side is retired at that point, so any token answered afterwards gets a zero-length packet. The CPU can also clear its own bank to drop a packet that would go out a frame late.

The serial-engine side is a three-state machine:
- TX_IDLE goes to TX_SEND on a token when the transmit bank holds data, and to TX_DONE on a token when it is empty.
- TX_SEND stays put until the last byte is accepted, then goes to TX_DONE.
- TX_DONE always returns to TX_IDLE.

The timer is a two-state machine:
- TMR_DISARMED goes to TMR_RUNNING on SOF.
- TMR_RUNNING reloads on SOF, and goes to TMR_DISARMED when it expires at zero.

Top module: `iso_in_pingpong`

## Requirements
- R1: Each CPU write stores `cpu_wr_data` at the next free position of the CPU-side bank. Each bank holds up to DEPTH (64) bytes and keeps its own byte count.
- R2: A cycle with `sof` high swaps the banks. From the next cycle `tx_len` equals the count the CPU-side bank had, and the new CPU-side bank starts empty.
- R3: An IN token (`in_req` high for one cycle in TX_IDLE) with a non-empty transmit bank streams its bytes in write order. Byte 0 is valid in the cycle after the token. `tx_valid` stays high and the byte index holds while `tx_ready` is low. `tx_tr` pulses for exactly one cycle, in the cycle after the last byte is accepted.
- R4: An IN token with an empty transmit bank gives a zero-length packet. `tx_valid` never rises and `tx_tr` pulses in the cycle after the token.
- R5: The transmit bank is unchanged between swaps, so every token in the same frame gets the same packet.
- R6: `cpu_clr` empties the CPU-side bank, and a write in the same cycle is dropped. The transmit bank is not affected.
- R7: When `sof` and `cpu_clr` occur in the same cycle, the swap happens first. The bank that has just become CPU-side is cleared, and the packet moved to the transmit side stays intact.
- R8: A write in the same cycle as `sof` becomes byte 0 of the new CPU-side bank.
- R9: A write to a full CPU-side bank is ignored and sets `cpu_ovf`, which stays high until reset.
- R10: `tmo_irq` is a one-cycle pulse. It is high in the cycle after the (reload+1)-th clock edge that follows the edge sampling `sof`, and it fires only once per SOF. It never fires before the first SOF, and an SOF at the expiry point prevents it.
- R11: On expiry no swap takes place. The transmit bank count drops to zero, so later tokens get zero-length packets, while the CPU-side bank keeps its contents.
- R12: After reset, `tx_len`, `tx_valid`, `tx_tr`, `tmo_irq` and `cpu_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | DATA_W | CPU write byte |
| cpu_clr | input | 1 | Empty the CPU-side bank |
| sof | input | 1 | Start-of-frame pulse |
| tmo_reload | input | TMO_W | Timer reload value in clock cycles |
| in_req | input | 1 | IN-token request, one-cycle pulse |
| tx_ready | input | 1 | Serial engine accepts the current byte |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_data | output | DATA_W | Transmit byte |
| tx_len | output | $clog2(DEPTH+1) | Byte count of the transmit-side bank |
| tx_tr | output | 1 | Transfer-done pulse |
| tmo_irq | output | 1 | Missing-SOF timeout pulse |
| cpu_ovf | output | 1 | Sticky CPU overflow flag |

## Verification
Three collisions are driven on purpose: SOF with a CPU clear, SOF with a CPU write, and SOF with the timer reaching zero. In each case the bench raises the strobes in the same cycle. Afterwards it reads `tx_len` and then sends a token, to see which bank each event hit. The behavioural model applies the rule order swap, then clear, then write, and the timer yields to SOF. The model's outputs are compared with the design's outputs on every clock.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_DONE = 2'd2
    } tx_state_e;

    typedef enum logic {
        TMR_DISARMED = 1'b0,
        TMR_RUNNING  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/iso_bank_store.sv
module iso_bank_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpu_clr,
    input  logic              swap,
    input  logic              retire,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  tx_count,
    output logic              ovf
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [2][DEPTH];
    logic [CNT_W-1:0]  cnt [2];
    logic              cpu_sel;
    logic              next_sel;
    logic [CNT_W-1:0]  base;
    logic              do_wr;
    logic              wr_ovf;
    logic              ovf_q;

    // Order inside one cycle: swap, then clear, then write.
    always_comb begin
        next_sel = swap ? ~cpu_sel : cpu_sel;
        base     = (swap || cpu_clr) ? '0 : cnt[cpu_sel];
        do_wr    = wr_en && !cpu_clr && (base != FULL);
        wr_ovf   = wr_en && !cpu_clr && (base == FULL);
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[next_sel][base[IDX_W-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_sel <= 1'b0;
            ovf_q   <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                cnt[b] <= '0;
            end
        end else begin
            cpu_sel <= next_sel;
            ovf_q   <= ovf_q | wr_ovf;
            for (int b = 0; b < 2; b++) begin
                if (1'(b) == next_sel) begin
                    cnt[b] <= base + CNT_W'(do_wr);
                end else if (retire) begin
                    cnt[b] <= '0;
                end
            end
        end
    end

    assign tx_count = cnt[~cpu_sel];
    assign rd_data  = mem[~cpu_sel][rd_idx];
    assign ovf      = ovf_q;

    // R2
    swap_moves_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> tx_count == $past(cnt[cpu_sel]));

    // R2
    swap_empties_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !wr_en) |=> cnt[cpu_sel] == '0);

    // R6
    clr_keeps_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clr && !swap && !retire) |=> (tx_count == $past(tx_count)) && (cnt[cpu_sel] == '0));

    // R9
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !swap && !cpu_clr && cnt[cpu_sel] == FULL) |=> (ovf && cnt[cpu_sel] == FULL));

    // R11
    retire_empties_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> tx_count == '0);

endmodule

// File: rtl/iso_frame_timer.sv
module iso_frame_timer
    import iso_pp_pkg::*;
#(
    parameter int TMO_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic [TMO_W-1:0] reload,
    output logic             fire,
    output logic             irq
);

    tmr_state_e       state;
    tmr_state_e       state_nxt;
    logic [TMO_W-1:0] cnt;
    logic             irq_q;

    always_comb begin
        state_nxt = state;
        unique case (state)
            TMR_DISARMED: state_nxt = sof ? TMR_RUNNING : TMR_DISARMED;
            TMR_RUNNING: begin
                if (sof) begin
                    state_nxt = TMR_RUNNING;
                end else if (cnt == '0) begin
                    state_nxt = TMR_DISARMED;
                end
            end
            default: state_nxt = TMR_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TMR_DISARMED;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= fire;
            if (sof) begin
                cnt <= reload;
            end else if (state == TMR_RUNNING && cnt != '0) begin
                cnt <= cnt - TMO_W'(1);
            end
        end
    end

    always_comb begin
        fire = (state == TMR_RUNNING) && (cnt == '0) && !sof;
        irq  = irq_q;
    end

    // R10
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10
    sof_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !irq);

    // R10
    disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TMR_DISARMED && !sof) |=> !irq);

endmodule

// File: rtl/iso_tx_fsm.sv
module iso_tx_fsm
    import iso_pp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic             tx_ready,
    input  logic [CNT_W-1:0] tx_count,
    output logic [IDX_W-1:0] rd_idx,
    output logic             tx_valid,
    output logic             tx_tr
);

    tx_state_e        state;
    tx_state_e        state_nxt;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] len_q;
    logic             last_beat;

    assign last_beat = (idx == len_q - CNT_W'(1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_IDLE: begin
                if (in_req) begin
                    state_nxt = (tx_count == '0) ? TX_DONE : TX_SEND;
                end
            end
            TX_SEND: begin
                if (tx_ready && last_beat) begin
                    state_nxt = TX_DONE;
                end
            end
            TX_DONE: state_nxt = TX_IDLE;
            default: state_nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            idx   <= '0;
            len_q <= '0;
        end else begin
            state <= state_nxt;
            if (state == TX_IDLE && in_req) begin
                idx   <= '0;
                len_q <= tx_count;
            end else if (state == TX_SEND && tx_ready && !last_beat) begin
                idx <= idx + CNT_W'(1);
            end
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_tr    = 1'b0;
        unique case (state)
            TX_IDLE: ;
            TX_SEND: tx_valid = 1'b1;
            TX_DONE: tx_tr    = 1'b1;
            default: ;
        endcase
        rd_idx = idx[IDX_W-1:0];
    end

    // R3
    tr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tr |=> (!tx_tr && !tx_valid));

    // R3
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(rd_idx)));

    // R4
    empty_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && in_req && tx_count == '0) |=> (tx_tr && !tx_valid));

endmodule

// File: rtl/iso_in_pingpong.sv
module iso_in_pingpong #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int TMO_W  = 18,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_clr,
    input  logic              sof,
    input  logic [TMO_W-1:0]  tmo_reload,
    input  logic              in_req,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic [CNT_W-1:0]  tx_len,
    output logic              tx_tr,
    output logic              tmo_irq,
    output logic              cpu_ovf
);

    logic              tmr_fire;
    logic [IDX_W-1:0]  rd_idx;
    logic [CNT_W-1:0]  tx_count;

    iso_bank_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr_en),
        .wr_data  (cpu_wr_data),
        .cpu_clr  (cpu_clr),
        .swap     (sof),
        .retire   (tmr_fire),
        .rd_idx   (rd_idx),
        .rd_data  (tx_data),
        .tx_count (tx_count),
        .ovf      (cpu_ovf)
    );

    iso_frame_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sof    (sof),
        .reload (tmo_reload),
        .fire   (tmr_fire),
        .irq    (tmo_irq)
    );

    iso_tx_fsm #(
        .DEPTH (DEPTH)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_req   (in_req),
        .tx_ready (tx_ready),
        .tx_count (tx_count),
        .rd_idx   (rd_idx),
        .tx_valid (tx_valid),
        .tx_tr    (tx_tr)
    );

    assign tx_len = tx_count;

endmodule

// File: tb/tb_iso_in_pingpong.sv
module tb_iso_in_pingpong;

    localparam int DEPTH  = 64;
    localparam int DATA_W = 8;
    localparam int TMO_W  = 18;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              cpu_wr_en = 1'b0;
    logic [DATA_W-1:0] cpu_wr_data = '0;
    logic              cpu_clr = 1'b0;
    logic              sof = 1'b0;
    logic [TMO_W-1:0]  tmo_reload = '0;
    logic              in_req = 1'b0;
    logic              tx_ready = 1'b0;
    logic              tx_valid;
    logic [DATA_W-1:0] tx_data;
    logic [CNT_W-1:0]  tx_len;
    logic              tx_tr;
    logic              tmo_irq;
    logic              cpu_ovf;

    iso_in_pingpong #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TMO_W(TMO_W)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_clr(cpu_clr), .sof(sof), .tmo_reload(tmo_reload), .in_req(in_req),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_len(tx_len),
        .tx_tr(tx_tr), .tmo_irq(tmo_irq), .cpu_ovf(cpu_ovf)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic expect_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model
    int   m_cb;
    int   m_cnt [2];
    int   m_mem [2][DEPTH];
    bit   m_ovf, m_armed, m_irq;
    int   m_tcnt, m_ts, m_idx, m_len;

    always @(posedge clk) begin : model
        int txc;
        bit fire;
        if (!rst_n) begin
            m_cb = 0; m_cnt[0] = 0; m_cnt[1] = 0;
            m_ovf = 0; m_armed = 0; m_irq = 0;
            m_tcnt = 0; m_ts = 0; m_idx = 0; m_len = 0;
        end else begin
            txc = m_cnt[1 - m_cb];
            case (m_ts)
                0: if (in_req) begin
                       m_len = txc; m_idx = 0;
                       m_ts = (txc == 0) ? 2 : 1;
                   end
                1: if (tx_ready) begin
                       if (m_idx == m_len - 1) m_ts = 2;
                       else m_idx++;
                   end
                default: m_ts = 0;
            endcase
            fire = m_armed && (m_tcnt == 0) && !sof;
            m_irq = fire;
            if (sof) begin
                m_tcnt = int'(tmo_reload); m_armed = 1;
            end else if (m_armed) begin
                if (m_tcnt == 0) m_armed = 0;
                else m_tcnt--;
            end
            if (sof) begin
                m_cb = 1 - m_cb; m_cnt[m_cb] = 0;
            end else if (fire) begin
                m_cnt[1 - m_cb] = 0;
            end
            if (cpu_clr) begin
                m_cnt[m_cb] = 0;
            end else if (cpu_wr_en) begin
                if (m_cnt[m_cb] < DEPTH) begin
                    m_mem[m_cb][m_cnt[m_cb]] = int'(cpu_wr_data);
                    m_cnt[m_cb]++;
                end else begin
                    m_ovf = 1;
                end
            end
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            expect_eq("R2 tx_len vs model", int'(tx_len), m_cnt[1 - m_cb]);
            expect_eq("R3 tx_valid vs model", int'(tx_valid), int'(m_ts == 1));
            if (m_ts == 1) expect_eq("R3 tx_data vs model", int'(tx_data), m_mem[1 - m_cb][m_idx]);
            expect_eq("R3 tx_tr vs model", int'(tx_tr), int'(m_ts == 2));
            expect_eq("R10 tmo_irq vs model", int'(tmo_irq), int'(m_irq));
            expect_eq("R9 cpu_ovf vs model", int'(cpu_ovf), int'(m_ovf));
        end
    end

    task automatic wr_bytes(int n, int seed);
        for (int i = 0; i < n; i++) begin
            cpu_wr_en = 1'b1;
            cpu_wr_data = DATA_W'((seed + i) & 255);
            @(negedge clk);
        end
        cpu_wr_en = 1'b0;
    endtask

    task automatic pulse_sof();
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
    endtask

    task automatic token(string req, int exp_n, int seed, bit stall);
        int got[$];
        int cyc = 0;
        bit saw_tr = 1'b0;
        in_req = 1'b1;
        @(negedge clk);
        in_req = 1'b0;
        while (!saw_tr && cyc < 400) begin
            if (tx_tr) begin
                saw_tr = 1'b1;
            end else begin
                tx_ready = stall ? ((cyc % 3) != 2) : 1'b1;
                if (tx_valid && tx_ready) got.push_back(int'(tx_data));
                @(negedge clk);
                cyc++;
            end
        end
        tx_ready = 1'b0;
        @(negedge clk);
        expect_eq({req, " done pulse seen"}, int'(saw_tr), 1);
        expect_eq({req, " packet length"}, got.size(), exp_n);
        foreach (got[i]) begin
            if (i < exp_n) expect_eq({req, " packet byte"}, got[i], (seed + i) & 255);
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int first_irq;
        int irq_hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        expect_eq("R12 tx_len after reset", int'(tx_len), 0);
        expect_eq("R12 tx_valid after reset", int'(tx_valid), 0);
        expect_eq("R12 tx_tr after reset", int'(tx_tr), 0);
        expect_eq("R12 tmo_irq after reset", int'(tmo_irq), 0);
        expect_eq("R12 cpu_ovf after reset", int'(cpu_ovf), 0);

        // R10 no interrupt before any SOF, even with a zero reload
        irq_hits = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (tmo_irq) irq_hits++;
        end
        expect_eq("R10 no irq before first SOF", irq_hits, 0);
        tmo_reload = TMO_W'(5000);

        // R1 R2 R3 write, swap, stream
        wr_bytes(10, 8'h10);
        expect_eq("R2 tx_len before swap", int'(tx_len), 0);
        pulse_sof();
        expect_eq("R2 tx_len after swap", int'(tx_len), 10);
        token("R3 full-rate packet", 10, 8'h10, 1'b0);
        // R5 same packet again with back-pressure
        token("R5 repeat token stalled", 10, 8'h10, 1'b1);

        // R4 empty transmit bank
        pulse_sof();
        token("R4 zero-length packet", 0, 0, 1'b0);

        // R9 overflow
        expect_eq("R9 ovf clear before fill", int'(cpu_ovf), 0);
        wr_bytes(66, 8'h40);
        expect_eq("R9 ovf set after excess writes", int'(cpu_ovf), 1);
        pulse_sof();
        expect_eq("R9 count capped at depth", int'(tx_len), DEPTH);
        token("R9 capped packet", DEPTH, 8'h40, 1'b0);

        // R6 clear with concurrent write
        wr_bytes(5, 8'h70);
        cpu_clr = 1'b1; cpu_wr_en = 1'b1; cpu_wr_data = 8'hEE;
        @(negedge clk);
        cpu_clr = 1'b0; cpu_wr_en = 1'b0;
        expect_eq("R6 tx side untouched by clear", int'(tx_len), DEPTH);
        wr_bytes(3, 8'h80);
        pulse_sof();
        token("R6 packet after clear", 3, 8'h80, 1'b0);

        // R7 SOF and clear in the same cycle
        wr_bytes(4, 8'h90);
        sof = 1'b1; cpu_clr = 1'b1;
        @(negedge clk);
        sof = 1'b0; cpu_clr = 1'b0;
        expect_eq("R7 swapped packet intact", int'(tx_len), 4);
        token("R7 packet after sof+clear", 4, 8'h90, 1'b1);
        pulse_sof();
        expect_eq("R7 new cpu bank was cleared", int'(tx_len), 0);

        // R8 write in the SOF cycle
        wr_bytes(2, 8'hA0);
        sof = 1'b1; cpu_wr_en = 1'b1; cpu_wr_data = 8'hB0;
        @(negedge clk);
        sof = 1'b0;
        cpu_wr_data = 8'hB1;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        token("R8 old packet", 2, 8'hA0, 1'b0);
        pulse_sof();
        token("R8 sof-cycle byte first", 2, 8'hB0, 1'b0);

        // R10 R11 missing SOF
        tmo_reload = TMO_W'(20);
        wr_bytes(6, 8'hC0);
        pulse_sof();
        wr_bytes(3, 8'hD0);
        first_irq = 0;
        irq_hits = 0;
        for (int k = 4; k <= 60; k++) begin
            @(negedge clk);
            if (tmo_irq) begin
                irq_hits++;
                if (first_irq == 0) first_irq = k;
            end
        end
        expect_eq("R10 irq cycle after SOF", first_irq, 21);
        expect_eq("R10 single irq per SOF", irq_hits, 1);
        expect_eq("R11 stale packet retired", int'(tx_len), 0);
        token("R11 zero-length after timeout", 0, 0, 1'b0);
        tmo_reload = TMO_W'(5000);
        pulse_sof();
        token("R11 cpu bank kept across lost frame", 3, 8'hD0, 1'b0);

        // R10 SOF at the expiry point suppresses the interrupt
        tmo_reload = TMO_W'(3);
        pulse_sof();
        tmo_reload = TMO_W'(5000);
        repeat (3) @(negedge clk);
        pulse_sof();
        irq_hits = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (tmo_irq) irq_hits++;
        end
        expect_eq("R10 SOF at expiry blocks irq", irq_hits, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule